// File: doc/BRIEF.md
# Crossbar-Aware GPIO Port Register

This block is one 8-bit general-purpose I/O port for a small microcontroller. It holds a port data latch and a per-bit output-mode register, and it turns them into per-pin drive-enable and drive-value signals for the pad ring. A pin crossbar sits beside it. For every pin the crossbar says whether a peripheral owns the pin, whether that peripheral drives it or only listens, and what value the peripheral wants driven. A single global enable gates every driver in the port until the crossbar has been set up.

The CPU writes the latch one byte at a time or one bit at a time, and it writes the mode register one byte at a time. Pin levels come back through a two-flop synchronizer. A plain read returns those synchronized levels. A read marked as read-modify-write returns the latch instead, so that an instruction that reads, changes and writes back one bit does not copy the state of other pins into their latch bits.

Top module: `gpio_xbar_port`

## Requirements
- R1: After reset the latch holds all ones and the mode register holds all zeros. Every mode bit is then 0, which selects open-drain. While the global enable is low, drv_en is 0.
- R2: With rd_rmw low, rd_data returns the value that pin_in had two rising clock edges earlier. Ownership of the pin by a peripheral does not change this.
- R3: With rd_rmw high, rd_data returns the port data latch.
- R4: While xbar_en is 0, drv_en and drv_val are 0 on every pin, whatever the latch, mode and ownership inputs hold.
- R5: A mode bit of 1 selects push-pull. An unowned push-pull pin drives (drv_en=1) and its drv_val equals its latch bit.
- R6: A mode bit of 0 selects open-drain. An unowned open-drain pin drives 0 when its latch bit is 0, and it is released (drv_en=0) when its latch bit is 1.
- R7: A pin with periph_own=1 and periph_dir_out=1 takes its drive level from periph_val, using the same push-pull or open-drain rule. Latch writes to that bit still update the latch but do not change the pin.
- R8: A pin with periph_own=1 and periph_dir_out=0 has drv_en=0, whatever the latch and mode settings are.
- R9: A single-bit write (bit_we high, byte_we low) sets latch bit bit_sel to bit_val at the next clock edge. The other seven bits keep their values.
- R10: A byte write sets the whole latch to byte_data. If a bit write is requested in the same cycle, the byte write wins and the bit write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_we | input | 1 | Write byte_data into the latch |
| byte_data | input | 8 | Latch byte write data |
| bit_we | input | 1 | Write one latch bit |
| bit_sel | input | 3 | Index of the latch bit to write |
| bit_val | input | 1 | Value for the single-bit write |
| mode_we | input | 1 | Write mode_data into the mode register |
| mode_data | input | 8 | Output mode per pin, 1 = push-pull, 0 = open-drain |
| rd_rmw | input | 1 | Read source select, 1 = latch, 0 = synchronized pins |
| rd_data | output | 8 | Read data |
| xbar_en | input | 1 | Global crossbar enable, 0 turns off every driver |
| periph_own | input | 8 | Pin is assigned to a peripheral |
| periph_dir_out | input | 8 | Owned pin is a peripheral output |
| periph_val | input | 8 | Peripheral output value |
| pin_in | input | 8 | Pad input levels, asynchronous |
| drv_en | output | 8 | Pad output driver enable |
| drv_val | output | 8 | Pad output level when enabled |

## Verification
The bench writes the latch through owned pins and confirms that rd_rmw still sees the new value while the pad does not move. A design that let the latch override the peripheral would fail here, and so would one that blocked the latch write altogether. Ownership as an input is combined with push-pull mode and a zero latch bit, which is the setting most likely to leak a driver. Reads are timed exactly two edges after pin changes, so a synchronizer that is one stage short or one stage long shows up as a mismatch. Byte writes and bit writes are issued in the same cycle to confirm that only the byte write lands, and single-bit writes are checked for disturbing neighbouring bits.

// File: rtl/gpio_xbar_port.sv
module gpio_xbar_port #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_we,
  input  logic [W-1:0]         byte_data,
  input  logic                 bit_we,
  input  logic [$clog2(W)-1:0] bit_sel,
  input  logic                 bit_val,
  input  logic                 mode_we,
  input  logic [W-1:0]         mode_data,
  input  logic                 rd_rmw,
  output logic [W-1:0]         rd_data,
  input  logic                 xbar_en,
  input  logic [W-1:0]         periph_own,
  input  logic [W-1:0]         periph_dir_out,
  input  logic [W-1:0]         periph_val,
  input  logic [W-1:0]         pin_in,
  output logic [W-1:0]         drv_en,
  output logic [W-1:0]         drv_val
);

  logic [W-1:0] port_lat;
  logic [W-1:0] out_mode;
  logic [W-1:0] sync_a, sync_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_lat <= '1;
      out_mode <= '0;
      sync_a   <= '0;
      sync_b   <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      if (mode_we) out_mode <= mode_data;
      if (byte_we)     port_lat          <= byte_data;
      else if (bit_we) port_lat[bit_sel] <= bit_val;
    end
  end

  logic [W-1:0] src, listen_only, may_drive;

  assign src         = (periph_own & periph_val) | (~periph_own & port_lat);
  assign listen_only = periph_own & ~periph_dir_out;
  assign may_drive   = out_mode | ~src;

  assign drv_en  = {W{xbar_en}} & ~listen_only & may_drive;
  assign drv_val = drv_en & src;
  assign rd_data = rd_rmw ? port_lat : sync_b;

endmodule

// File: rtl/gpio_xbar_port_chk.sv
module gpio_xbar_port_chk #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 byte_we,
  input logic [W-1:0]         byte_data,
  input logic                 bit_we,
  input logic [$clog2(W)-1:0] bit_sel,
  input logic                 rd_rmw,
  input logic [W-1:0]         rd_data,
  input logic                 xbar_en,
  input logic [W-1:0]         periph_own,
  input logic [W-1:0]         periph_dir_out,
  input logic [W-1:0]         periph_val,
  input logic [W-1:0]         pin_in,
  input logic [W-1:0]         drv_en,
  input logic [W-1:0]         drv_val,
  input logic [W-1:0]         port_lat,
  input logic [W-1:0]         out_mode
);

  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= '0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  // R4
  xbar_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |-> (drv_en == '0 && drv_val == '0));

  // R8
  input_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & periph_own & ~periph_dir_out) == '0);

  // R7
  periph_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_en & periph_own) & (drv_val ^ periph_val)) == '0);

  // R6
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~out_mode & ~periph_own & port_lat & drv_en) == '0);

  // R2
  pin_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 2'd2 && !rd_rmw) |-> rd_data == $past(pin_in, 2));

  // R9
  bit_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !byte_we) |=>
      ((port_lat ^ $past(port_lat)) & ~(W'(1) << $past(bit_sel))) == '0);

  // R10
  byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> port_lat == $past(byte_data));

endmodule

bind gpio_xbar_port gpio_xbar_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_data(byte_data),
  .bit_we(bit_we), .bit_sel(bit_sel), .rd_rmw(rd_rmw), .rd_data(rd_data),
  .xbar_en(xbar_en), .periph_own(periph_own), .periph_dir_out(periph_dir_out),
  .periph_val(periph_val), .pin_in(pin_in), .drv_en(drv_en), .drv_val(drv_val),
  .port_lat(port_lat), .out_mode(out_mode)
);

// File: tb/gpio_xbar_port_tb.sv
`timescale 1ns/1ps
module gpio_xbar_port_tb;
  logic clk = 0, rst_n = 0;
  logic byte_we = 0, bit_we = 0, bit_val = 0, mode_we = 0, rd_rmw = 0, xbar_en = 0;
  logic [7:0] byte_data = 0, mode_data = 0, periph_own = 0, periph_dir_out = 0;
  logic [7:0] periph_val = 0, pin_in = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] rd_data, drv_en, drv_val;

  always #10 clk = ~clk;

  gpio_xbar_port u_dut (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0] m_lat, m_mode;
  logic [7:0] pin_hist[$];
  string rd_tag = "";

  task automatic model_edge();
    if (!rst_n) begin
      m_lat = 8'hFF; m_mode = 8'h00; pin_hist.delete();
    end else begin
      pin_hist.push_back(pin_in);
      if (mode_we) m_mode = mode_data;
      if (byte_we) m_lat = byte_data;
      else if (bit_we) m_lat[bit_sel] = bit_val;
    end
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    if (rd_rmw) exp_rd = m_lat;
    else exp_rd = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 8'h00;
    vectors++;
    if (rd_data !== exp_rd) begin
      miscompares++;
      $display("FAIL %s rd_data act=%h exp=%h", rd_tag != "" ? rd_tag : (rd_rmw ? "R3" : "R2"),
               rd_data, exp_rd);
    end
    for (int i = 0; i < 8; i++) begin
      logic e_en, e_val, v;
      string tag;
      if (!xbar_en) begin e_en = 0; tag = "R4"; end
      else if (periph_own[i] && !periph_dir_out[i]) begin e_en = 0; tag = "R8"; end
      else begin
        v = periph_own[i] ? periph_val[i] : m_lat[i];
        e_en = m_mode[i] ? 1'b1 : !v;
        tag = periph_own[i] ? "R7" : (m_mode[i] ? "R5" : "R6");
      end
      e_val = e_en && (periph_own[i] ? periph_val[i] : m_lat[i]);
      vectors++;
      if (drv_en[i] !== e_en || drv_val[i] !== e_val) begin
        miscompares++;
        $display("FAIL %s pin%0d en/val act=%b%b exp=%b%b", tag, i, drv_en[i], drv_val[i],
                 e_en, e_val);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    byte_we = 0; bit_we = 0; mode_we = 0;
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    // R1: reset values seen through rmw read and disabled drivers
    rd_rmw = 1; rd_tag = "R1"; tick();
    rd_tag = "";
    // R4: latch and mode changes with crossbar off
    byte_we = 1; byte_data = 8'h00; mode_we = 1; mode_data = 8'hFF; tick(); idle(); tick();
    // R6: open-drain
    xbar_en = 1; mode_we = 1; mode_data = 8'h00; tick(); idle();
    byte_we = 1; byte_data = 8'h5A; tick(); idle(); tick();
    // R5: push-pull, mixed modes
    mode_we = 1; mode_data = 8'hFF; tick(); mode_data = 8'h0F; tick(); idle(); tick();
    // R9: single-bit writes
    rd_tag = "R9";
    for (int i = 0; i < 8; i++) begin
      bit_we = 1; bit_sel = 3'(i); bit_val = i[0]; tick();
    end
    idle(); tick();
    // R10: byte write beats bit write
    rd_tag = "R10";
    byte_we = 1; byte_data = 8'hC3; bit_we = 1; bit_sel = 3'd0; bit_val = 0; tick();
    idle(); tick();
    rd_tag = "";
    // R7/R8: ownership; latch writes must not move owned pins
    periph_own = 8'hF0; periph_dir_out = 8'h30; periph_val = 8'hA5; mode_we = 1;
    mode_data = 8'hFF; byte_we = 1; byte_data = 8'h00; tick(); idle();
    byte_data = 8'hFF; byte_we = 1; tick(); idle(); tick();
    mode_we = 1; mode_data = 8'h00; tick(); idle(); tick();
    // R2: pin reads two edges late, owned or not
    rd_rmw = 0;
    pin_in = 8'h81; tick(); pin_in = 8'h7E; tick(); pin_in = 8'h3C; tick(); tick(); tick();
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      byte_we = ($urandom % 4) == 0; byte_data = 8'($urandom);
      bit_we = ($urandom % 3) == 0; bit_sel = 3'($urandom); bit_val = 1'($urandom);
      mode_we = ($urandom % 6) == 0; mode_data = 8'($urandom);
      rd_rmw = 1'($urandom); xbar_en = ($urandom % 5) != 0;
      periph_own = 8'($urandom); periph_dir_out = 8'($urandom); periph_val = 8'($urandom);
      pin_in = 8'($urandom);
      tick();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule